// File: doc/BRIEF.md
# MSI and INTx Interrupt Aggregator

This block gathers message-signalled interrupt vectors and four legacy INTx request lines into banked pending and enable registers, and gives each bank its own level interrupt output towards the host. Vectors arrive either on a strobe with a vector number or as a register write to the message target offset. The 32 vectors are spread across 8 banks of 4 bits: vector v lands in bank v mod 8 at bit v div 8.

Software reaches the state through a 32-bit register slave port. Each bank has a status register (write 1 to clear), an enable-set register and an enable-clear register. Clearing any status bit of a bank counts as the acknowledge. From then on the bank's output stays low until software writes the bank's code to the end-of-interrupt register. That write re-arms the output. This keeps one bank from raising a second request before the first one has been fully serviced.

Top module: `irq_aggr_top`

## Requirements
- R1: After synchronous reset, all pending and enable bits read 0, every bank is armed, and all interrupt outputs are low.
- R2: A strobe on `msi_valid_i` with vector v sets pending bit v div 8 of MSI bank v mod 8. Vectors 0, 8, 16 and 24 land in bank 0, bits 0 to 3.
- R3: A register write to offset 0x054 injects vector `reg_wdata_i[4:0]` exactly as a strobe would.
- R4: The status of MSI bank n reads at 0x104 + 16*n, in bits [3:0]. Writing a 1 to a status bit clears it. Writing a 0 leaves it unchanged.
- R5: Writing 1s to 0x108 + 16*n sets those enable bits of bank n. Writing 1s to 0x10C + 16*n clears them. A read at either offset returns the bank's enable bits.
- R6: A bank's output is high while the bank is armed and at least one bit is both pending and enabled. A pending bit without its enable is kept in status but leaves the output low.
- R7: A status write with any 1 bit in a bank disarms that bank from the next cycle. The output then stays low, even for new vectors, until a write to 0x050 carries the value n+4 for MSI bank n, or i for INTx line i.
- R8: When a vector sets a bit in the same cycle that a status write clears that bit, the bit stays pending.
- R9: A high level on `intx_i[i]` sets bit 0 of the INTx status at 0x184 + 16*i. The enable-set is at 0x188 + 16*i and the enable-clear is at 0x18C + 16*i. Line i drives `intx_irq_o[i]` under the same arming rule as R6 and R7.
- R10: An end-of-interrupt value that names another bank or line leaves this bank's arming unchanged.
- R11: Read data appears on `reg_rdata_o` one cycle after the read request. Offsets that map to no register read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msi_valid_i | input | 1 | Vector strobe |
| msi_vector_i | input | 5 | Vector number carried by the strobe |
| intx_i | input | 4 | Legacy INTx request levels |
| reg_en_i | input | 1 | Register access request |
| reg_we_i | input | 1 | 1 for write, 0 for read |
| reg_addr_i | input | 12 | Byte offset of the register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid one cycle after the request |
| msi_irq_o | output | 8 | Level interrupt output of each MSI bank |
| intx_irq_o | output | 4 | Level interrupt output of each INTx line |

## Verification
The hardest state to reach is a disarmed bank that has fresh, enabled pending bits. In that state the output must stay low until the matching end-of-interrupt code arrives, and not when some other code arrives. The stimulus enables a bank, acknowledges it through its status register, injects a new vector, and then sends a wrong end-of-interrupt code before the right one. A sweep over all 32 vectors checks the interleaved bank and bit placement. A separate test sets and clears the same bit in the same cycle.

// File: rtl/irq_aggr_pkg.sv
package irq_aggr_pkg;

    // Register offsets that software and the interrupt mapping depend on
    localparam logic [31:0] EOI_OFS    = 32'h050;
    localparam logic [31:0] TARGET_OFS = 32'h054;
    localparam logic [31:0] MSI_BASE   = 32'h100;
    localparam logic [31:0] INTX_BASE  = 32'h180;
    localparam int          BANK_STRIDE = 16;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_STATUS,
        ACC_EN_SET,
        ACC_EN_CLR
    } acc_kind_e;

    typedef struct packed {
        logic      hit_msi;
        logic      hit_intx;
        logic [7:0] idx;
        acc_kind_e kind;
        logic      is_eoi;
        logic      is_target;
    } reg_dec_t;

    // Register kind selected by the low nibble inside a bank window
    function automatic acc_kind_e nibble_kind(input logic [3:0] nib);
        case (nib)
            4'h4:    return ACC_STATUS;
            4'h8:    return ACC_EN_SET;
            4'hC:    return ACC_EN_CLR;
            default: return ACC_NONE;
        endcase
    endfunction

endpackage

// File: rtl/irq_regdec.sv
module irq_regdec
    import irq_aggr_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NUM_BANKS = 8,
    parameter int NUM_INTX  = 4
) (
    input  logic [ADDR_W-1:0] addr_i,
    output reg_dec_t          dec_o
);
    localparam logic [31:0] MSI_END  = MSI_BASE  + 32'(BANK_STRIDE * NUM_BANKS);
    localparam logic [31:0] INTX_END = INTX_BASE + 32'(BANK_STRIDE * NUM_INTX);

    logic [31:0] a;
    logic [31:0] rel_m;
    logic [31:0] rel_i;
    acc_kind_e   kind;

    always_comb begin
        a     = 32'(addr_i);
        rel_m = (a - MSI_BASE) >> 4;
        rel_i = (a - INTX_BASE) >> 4;
        kind  = nibble_kind(a[3:0]);
        dec_o = '0;
        dec_o.kind      = kind;
        dec_o.is_eoi    = (a == EOI_OFS);
        dec_o.is_target = (a == TARGET_OFS);
        if (a >= MSI_BASE && a < MSI_END) begin
            dec_o.hit_msi = (kind != ACC_NONE);
            dec_o.idx     = rel_m[7:0];
        end else if (a >= INTX_BASE && a < INTX_END) begin
            dec_o.hit_intx = (kind != ACC_NONE);
            dec_o.idx      = rel_i[7:0];
        end
    end

endmodule

// File: rtl/irq_bank.sv
module irq_bank #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] set_i,
    input  logic [WIDTH-1:0] clr_i,
    input  logic [WIDTH-1:0] en_set_i,
    input  logic [WIDTH-1:0] en_clr_i,
    input  logic             eoi_i,
    output logic [WIDTH-1:0] pend_o,
    output logic [WIDTH-1:0] en_o,
    output logic             irq_o
);
    logic armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_o  <= '0;
            en_o    <= '0;
            armed_q <= 1'b1;
        end else begin
            // a new request outranks a clear of the same bit
            pend_o <= (pend_o & ~clr_i) | set_i;
            en_o   <= (en_o & ~en_clr_i) | en_set_i;
            if (eoi_i)
                armed_q <= 1'b1;
            else if (|clr_i)
                armed_q <= 1'b0;
        end
    end

    assign irq_o = armed_q & (|(pend_o & en_o));

    assert_set_sticks_R8: assert property (@(posedge clk) disable iff (rst)
        (set_i != '0) |=> ((pend_o & $past(set_i)) == $past(set_i)));

    assert_w1c_clears_R4: assert property (@(posedge clk) disable iff (rst)
        ((clr_i & ~set_i) != '0) |=> ((pend_o & $past(clr_i & ~set_i)) == '0));

    assert_enable_set_R5: assert property (@(posedge clk) disable iff (rst)
        (en_set_i != '0) |=> ((en_o & $past(en_set_i)) == $past(en_set_i)));

    assert_ack_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        ((clr_i != '0) && !eoi_i) |=> !irq_o);

    assert_eoi_rearm_R7: assert property (@(posedge clk) disable iff (rst)
        (eoi_i && ((pend_o & en_o & ~clr_i & ~en_clr_i) != '0)) |=> irq_o);

endmodule

// File: rtl/irq_aggr_top.sv
module irq_aggr_top
    import irq_aggr_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int BANK_BITS = 4,
    parameter int NUM_INTX  = 4,
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32
) (
    input  logic                                       clk,
    input  logic                                       rst,
    input  logic                                       msi_valid_i,
    input  logic [$clog2(NUM_BANKS*BANK_BITS)-1:0]     msi_vector_i,
    input  logic [NUM_INTX-1:0]                        intx_i,
    input  logic                                       reg_en_i,
    input  logic                                       reg_we_i,
    input  logic [ADDR_W-1:0]                          reg_addr_i,
    input  logic [DATA_W-1:0]                          reg_wdata_i,
    output logic [DATA_W-1:0]                          reg_rdata_o,
    output logic [NUM_BANKS-1:0]                       msi_irq_o,
    output logic [NUM_INTX-1:0]                        intx_irq_o
);
    localparam int NUM_VEC = NUM_BANKS * BANK_BITS;
    localparam int VEC_W   = $clog2(NUM_VEC);

    reg_dec_t dec;
    logic     wr;
    logic     rd;
    logic     tgt_wr;
    logic     eoi_wr;

    logic [BANK_BITS-1:0] m_pend [NUM_BANKS];
    logic [BANK_BITS-1:0] m_en   [NUM_BANKS];
    logic                 i_pend [NUM_INTX];
    logic                 i_en   [NUM_INTX];
    logic [DATA_W-1:0]    rd_val;

    irq_regdec #(
        .ADDR_W   (ADDR_W),
        .NUM_BANKS(NUM_BANKS),
        .NUM_INTX (NUM_INTX)
    ) u_dec (
        .addr_i(reg_addr_i),
        .dec_o (dec)
    );

    assign wr     = reg_en_i & reg_we_i;
    assign rd     = reg_en_i & ~reg_we_i;
    assign tgt_wr = wr & dec.is_target;
    assign eoi_wr = wr & dec.is_eoi;

    for (genvar n = 0; n < NUM_BANKS; n++) begin : g_msi
        logic [BANK_BITS-1:0] set_v, clr_v, ens_v, enc_v;
        logic                 sel, eoi_n;

        assign sel   = wr && dec.hit_msi && (dec.idx == 8'(n));
        assign eoi_n = eoi_wr && (reg_wdata_i == DATA_W'(NUM_INTX + n));

        for (genvar b = 0; b < BANK_BITS; b++) begin : g_bit
            // vector n + NUM_BANKS*b lives in bank n, bit b
            assign set_v[b] =
                (msi_valid_i && (msi_vector_i == VEC_W'(n + NUM_BANKS * b))) ||
                (tgt_wr && (reg_wdata_i[VEC_W-1:0] == VEC_W'(n + NUM_BANKS * b)));
        end

        assign clr_v = (sel && dec.kind == ACC_STATUS) ? reg_wdata_i[BANK_BITS-1:0] : '0;
        assign ens_v = (sel && dec.kind == ACC_EN_SET) ? reg_wdata_i[BANK_BITS-1:0] : '0;
        assign enc_v = (sel && dec.kind == ACC_EN_CLR) ? reg_wdata_i[BANK_BITS-1:0] : '0;

        irq_bank #(.WIDTH(BANK_BITS)) u_bank (
            .clk     (clk),
            .rst     (rst),
            .set_i   (set_v),
            .clr_i   (clr_v),
            .en_set_i(ens_v),
            .en_clr_i(enc_v),
            .eoi_i   (eoi_n),
            .pend_o  (m_pend[n]),
            .en_o    (m_en[n]),
            .irq_o   (msi_irq_o[n])
        );
    end

    for (genvar i = 0; i < NUM_INTX; i++) begin : g_intx
        logic sel, eoi_i_n;
        logic [0:0] set_l, clr_l, ens_l, enc_l, pend_l, en_l;

        assign sel     = wr && dec.hit_intx && (dec.idx == 8'(i));
        assign eoi_i_n = eoi_wr && (reg_wdata_i == DATA_W'(i));
        assign set_l   = intx_i[i];
        assign clr_l   = (sel && dec.kind == ACC_STATUS) ? reg_wdata_i[0] : 1'b0;
        assign ens_l   = (sel && dec.kind == ACC_EN_SET) ? reg_wdata_i[0] : 1'b0;
        assign enc_l   = (sel && dec.kind == ACC_EN_CLR) ? reg_wdata_i[0] : 1'b0;

        irq_bank #(.WIDTH(1)) u_line (
            .clk     (clk),
            .rst     (rst),
            .set_i   (set_l),
            .clr_i   (clr_l),
            .en_set_i(ens_l),
            .en_clr_i(enc_l),
            .eoi_i   (eoi_i_n),
            .pend_o  (pend_l),
            .en_o    (en_l),
            .irq_o   (intx_irq_o[i])
        );

        assign i_pend[i] = pend_l[0];
        assign i_en[i]   = en_l[0];
    end

    // read selection: status returns pending bits, either enable offset returns enables
    always_comb begin
        rd_val = '0;
        for (int n = 0; n < NUM_BANKS; n++) begin
            if (dec.hit_msi && dec.idx == 8'(n))
                rd_val[BANK_BITS-1:0] = (dec.kind == ACC_STATUS) ? m_pend[n] : m_en[n];
        end
        for (int i = 0; i < NUM_INTX; i++) begin
            if (dec.hit_intx && dec.idx == 8'(i))
                rd_val[0] = (dec.kind == ACC_STATUS) ? i_pend[i] : i_en[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            reg_rdata_o <= '0;
        else if (rd)
            reg_rdata_o <= rd_val;
    end

    assert_rst_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (msi_irq_o == '0 && intx_irq_o == '0));

endmodule

// File: tb/irq_aggr_top_test.sv
module irq_aggr_top_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        msi_valid = 1'b0;
    logic [4:0]  msi_vector = '0;
    logic [3:0]  intx = '0;
    logic        reg_en = 1'b0;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  msi_irq;
    logic [3:0]  intx_irq;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    irq_aggr_top uut (
        .clk         (clk),
        .rst         (rst),
        .msi_valid_i (msi_valid),
        .msi_vector_i(msi_vector),
        .intx_i      (intx),
        .reg_en_i    (reg_en),
        .reg_we_i    (reg_we),
        .reg_addr_i  (reg_addr),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata),
        .msi_irq_o   (msi_irq),
        .intx_irq_o  (intx_irq)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
        @(negedge clk);
        reg_en = 1'b0;
        d = reg_rdata;
    endtask

    task automatic strobe(input logic [4:0] v);
        @(negedge clk);
        msi_valid = 1'b1; msi_vector = v;
        @(negedge clk);
        msi_valid = 1'b0;
    endtask

    function automatic logic [11:0] m_stat(input int n); return 12'(32'h104 + 16 * n); endfunction
    function automatic logic [11:0] m_set (input int n); return 12'(32'h108 + 16 * n); endfunction
    function automatic logic [11:0] m_clr (input int n); return 12'(32'h10C + 16 * n); endfunction
    function automatic logic [11:0] i_stat(input int n); return 12'(32'h184 + 16 * n); endfunction

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check({24'b0, msi_irq}, 32'h0, "R1 msi outputs");
        check({28'b0, intx_irq}, 32'h0, "R1 intx outputs");
        for (int n = 0; n < 8; n++) begin
            rd(m_stat(n), d); check(d, 0, "R1 msi status");
            rd(m_set(n), d);  check(d, 0, "R1 msi enable");
        end
        for (int i = 0; i < 4; i++) begin
            rd(i_stat(i), d); check(d, 0, "R1 intx status");
        end

        // R2 sweep over every vector, R4 clear, R6 no output without enable
        for (int v = 0; v < 32; v++) begin
            strobe(5'(v));
            check({24'b0, msi_irq}, 0, "R6 disabled stays low");
            for (int n = 0; n < 8; n++) begin
                rd(m_stat(n), d);
                check(d, (n == v % 8) ? (32'h1 << (v / 8)) : 32'h0, "R2 placement");
            end
            wr(m_stat(v % 8), 32'h0000_000F);
            rd(m_stat(v % 8), d);
            check(d, 0, "R4 w1c");
            wr(12'h050, 32'(v % 8 + 4));
        end

        // R3 target offset injection
        for (int v = 5; v < 32; v += 9) begin
            wr(12'h054, 32'(v));
            rd(m_stat(v % 8), d);
            check(d, 32'h1 << (v / 8), "R3 target write");
            wr(m_stat(v % 8), 32'hF);
            wr(12'h050, 32'(v % 8 + 4));
        end

        // R5 enable set/clear, readable at both offsets
        wr(m_set(5), 32'hB);
        rd(m_set(5), d); check(d, 32'hB, "R5 enable set read");
        rd(m_clr(5), d); check(d, 32'hB, "R5 enable read at clr");
        wr(m_clr(5), 32'h9);
        rd(m_set(5), d); check(d, 32'h2, "R5 enable clear");
        wr(m_clr(5), 32'hF);

        // R6/R7/R10 arming sequence on bank 3
        wr(m_set(3), 32'hF);
        strobe(5'd19);
        check({24'b0, msi_irq}, 32'h08, "R6 bank3 asserted");
        wr(m_stat(3), 32'h0);
        check({24'b0, msi_irq}, 32'h08, "R4 zero write no ack");
        wr(m_stat(3), 32'h4);
        check({24'b0, msi_irq}, 0, "R7 ack drops output");
        strobe(5'd19);
        check({24'b0, msi_irq}, 0, "R7 disarmed ignores new vector");
        rd(m_stat(3), d); check(d, 32'h4, "R7 still pending");
        wr(12'h050, 32'd4);
        check({24'b0, msi_irq}, 0, "R10 wrong eoi");
        wr(12'h050, 32'd2);
        check({24'b0, msi_irq}, 0, "R10 intx eoi value");
        wr(12'h050, 32'd7);
        check({24'b0, msi_irq}, 32'h08, "R7 eoi rearms");

        // R8 set and clear in the same cycle
        @(negedge clk);
        msi_valid = 1'b1; msi_vector = 5'd19;
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = m_stat(3); reg_wdata = 32'h4;
        @(negedge clk);
        msi_valid = 1'b0; reg_en = 1'b0; reg_we = 1'b0;
        rd(m_stat(3), d); check(d, 32'h4, "R8 set wins");
        wr(m_stat(3), 32'hF);
        wr(12'h050, 32'd7);
        wr(m_clr(3), 32'hF);

        // R9 INTx lines
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); intx[i] = 1'b1;
            @(negedge clk); intx[i] = 1'b0;
            rd(i_stat(i), d); check(d, 1, "R9 intx status");
            check({28'b0, intx_irq}, 0, "R9 intx disabled");
            wr(12'(32'h188 + 16 * i), 32'h1);
            check({28'b0, intx_irq}, 32'h1 << i, "R9 intx asserted");
            wr(i_stat(i), 32'h1);
            check({28'b0, intx_irq}, 0, "R9 intx ack");
            @(negedge clk); intx[i] = 1'b1;
            @(negedge clk); intx[i] = 1'b0;
            check({28'b0, intx_irq}, 0, "R9 intx disarmed");
            wr(12'h050, 32'(i));
            check({28'b0, intx_irq}, 32'h1 << i, "R9 intx eoi");
            wr(12'(32'h18C + 16 * i), 32'h1);
            check({28'b0, intx_irq}, 0, "R9 intx enable clear");
            wr(i_stat(i), 32'h1);
        end

        // R11 unmapped offsets and latency
        wr(12'h054, 32'd1);
        rd(12'h0F0, d); check(d, 0, "R11 unmapped");
        rd(12'h110, d); check(d, 0, "R11 bank nibble 0");
        rd(12'h050, d); check(d, 0, "R11 eoi reads zero");
        rd(m_stat(1), d); check(d, 32'h1, "R11 read latency");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule